// File: doc/BRIEF.md
# Pseudorandom Fault Injector for a 128-bit Datapath

This block sits in series with a wide datapath bus and corrupts it on purpose so that error-detection logic downstream can be exercised. The bus is split into sixteen byte lanes. Each lane owns an 8-bit pseudorandom register that supplies replacement bits. Each bit of the lane has a two-way selector that passes either the true bit or the replacement bit. A separate 16-bit pseudorandom register decides in which cycles a fault fires and which lane, lanes or bit it strikes. The timing and location of faults are therefore random but repeatable from the seeds.

Four modes choose the fault shape: one flipped bit, one replaced byte, several replaced bytes at once, or a permanent stuck-at pattern that pins chosen lines to chosen levels. The data path is purely combinational, so with injection disabled the bus passes through with no added latency. Next to the bus, the block reports the effective error mask, which is the faulted bus XOR the true bus. Downstream logic can use it to tell whether a fault actually changed anything. A replacement bit that happens to equal the true bit is not counted.

Top module: `fault_injector`

## Requirements
- R1: While `inj_en` is 0, `bus_out` equals `bus_in` in the same cycle, `flip_mask` is 0 and `flip_any` is 0.
- R2: Lane k's replacement register (k = 0..15, lane k is bus bits 8k+7..8k) is a left-shifting 8-bit register whose new bit 0 is s[7]^s[5]^s[4]^s[3]. This is the polynomial x^8+x^6+x^5+x^4+1. Its seed is `data_seed` + k modulo 256. A seed of 0 is replaced by 8'hFF.
- R3: The select register is a left-shifting 16-bit register whose new bit 0 is s[15]^s[13]^s[12]^s[10]. Its seed is `sel_seed`. A seed of 0 is replaced by 16'hACE1, so the register is never zero.
- R4: A fault fires in a cycle when bits 15..13 of the select register are all 0. The target lane is select bits 3..0 and the target bit is select bits 6..4. No fault fires in any other cycle, for modes 0 to 2.
- R5: Mode 0 (single-bit): on a firing cycle only the target bit of the target lane takes the value of the matching bit of that lane's replacement register.
- R6: Mode 1 (single-byte): on a firing cycle the whole target lane takes that lane's replacement register value.
- R7: Mode 2 (multi-bit): on a firing cycle every lane k for which select bit k XOR select bit (k+8) mod 16 is 1 takes its replacement register value.
- R8: Mode 3 (stuck-at): while enabled, every bus line whose `stuck_mask` bit is 1 is driven to its `stuck_val` bit, and every other line passes through. The pseudorandom faults are not applied in this mode.
- R9: `flip_mask` equals `bus_out` XOR `bus_in`, and `flip_any` is 1 exactly when `flip_mask` is nonzero.
- R10: When `seed_load` is 1 at a clock edge, all registers load their seeds as given in R2 and R3, whatever `inj_en` is. The outputs in that cycle still use the old register contents.
- R11: Reset acts as a load of seeds 0 on both inputs. After that, all registers advance one step on each clock edge where `inj_en` is 1 and `seed_load` is 0, and hold on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_en | input | 1 | Enable injection and register stepping |
| inj_mode | input | 2 | 0 single-bit, 1 single-byte, 2 multi-bit, 3 stuck-at |
| seed_load | input | 1 | Load seeds into all pseudorandom registers |
| data_seed | input | 8 | Base seed for the lane replacement registers |
| sel_seed | input | 16 | Seed for the select register |
| stuck_mask | input | 128 | Lines forced in stuck-at mode |
| stuck_val | input | 128 | Forced levels in stuck-at mode |
| bus_in | input | 128 | True datapath bus |
| bus_out | output | 128 | Possibly faulted bus |
| flip_any | output | 1 | Some line differs from the true bus |
| flip_mask | output | 128 | Effective error mask |

## Verification
The hardest case to reach is a firing cycle in which the replacement bits partly or fully equal the true bits. There the block must drop those bits from the mask, and it may raise no strobe at all. The stimulus runs several hundred enabled cycles per mode with random bus words and several seeds. It also runs stretches with an all-zero and an all-one bus, so that both firing outcomes occur many times. It also pauses injection and reloads seeds mid-run, which shows that the registers hold and restart exactly where the requirements say.

// File: rtl/fault_injector.sv
module fault_injector #(
  parameter int          LANES      = 16,
  parameter int          W          = LANES * 8,
  parameter logic [15:0] SEL_DEFAULT = 16'hACE1,
  parameter logic [7:0]  DAT_DEFAULT = 8'hFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inj_en,
  input  logic [1:0]   inj_mode,
  input  logic         seed_load,
  input  logic [7:0]   data_seed,
  input  logic [15:0]  sel_seed,
  input  logic [W-1:0] stuck_mask,
  input  logic [W-1:0] stuck_val,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         flip_any,
  output logic [W-1:0] flip_mask
);

  localparam int LIDX = $clog2(LANES);

  function automatic logic [7:0] step8(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [15:0] step16(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [W-1:0] seed_vec(input logic [7:0] base);
    logic [W-1:0] v;
    logic [7:0]   s;
    for (int k = 0; k < LANES; k++) begin
      s = base + 8'(k);
      v[k*8 +: 8] = (s == 8'd0) ? DAT_DEFAULT : s;
    end
    return v;
  endfunction

  logic [15:0]  sel_q;
  logic [W-1:0] dat_q, dat_nx, rep;
  logic [15:0]  multi;
  logic         fire;
  logic [W-1:0] injected, stuck;

  always_comb
    for (int k = 0; k < LANES; k++) dat_nx[k*8 +: 8] = step8(dat_q[k*8 +: 8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_DEFAULT;
      dat_q <= seed_vec(8'd0);
    end else if (seed_load) begin
      sel_q <= (sel_seed == 16'd0) ? SEL_DEFAULT : sel_seed;
      dat_q <= seed_vec(data_seed);
    end else if (inj_en) begin
      sel_q <= step16(sel_q);
      dat_q <= dat_nx;
    end
  end

  assign fire  = (sel_q[15:13] == 3'b000);
  assign multi = sel_q ^ {sel_q[7:0], sel_q[15:8]};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic hit;
    assign hit = fire && (sel_q[LIDX-1:0] == LIDX'(i));
    always_comb begin
      case (inj_mode)
        2'd0:    rep[i*8 +: 8] = hit ? (8'd1 << sel_q[6:4]) : 8'd0;
        2'd1:    rep[i*8 +: 8] = hit ? 8'hFF : 8'd0;
        2'd2:    rep[i*8 +: 8] = (fire && multi[i]) ? 8'hFF : 8'd0;
        default: rep[i*8 +: 8] = 8'd0;
      endcase
    end
  end

  assign injected  = (bus_in & ~rep) | (dat_q & rep);
  assign stuck     = (bus_in & ~stuck_mask) | (stuck_val & stuck_mask);
  assign bus_out   = !inj_en ? bus_in : (inj_mode == 2'd3) ? stuck : injected;
  assign flip_mask = bus_out ^ bus_in;
  assign flip_any  = |flip_mask;

  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_en |-> (flip_mask == '0) && !flip_any);

  assert_single_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_en && inj_mode == 2'd0) |-> $countones(flip_mask) <= 1);

  assert_stuck_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_en && inj_mode == 2'd3) |-> ((bus_out ^ stuck_val) & stuck_mask) == '0);

  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && sel_seed != 16'd0) |=> sel_q == $past(sel_seed));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!inj_en && !seed_load) |=> $stable(sel_q) && $stable(dat_q));

  always @(posedge clk)
    if (rst_n) assert_sel_live_R3: assert (sel_q != 16'd0);

endmodule

// File: tb/fault_injector_tb_top.sv
module fault_injector_tb_top;
  localparam int W = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inj_en = 1'b0;
  logic [1:0]   inj_mode = 2'd0;
  logic         seed_load = 1'b0;
  logic [7:0]   data_seed = 8'd0;
  logic [15:0]  sel_seed = 16'd0;
  logic [W-1:0] stuck_mask = '0, stuck_val = '0, bus_in = '0;
  logic [W-1:0] bus_out, flip_mask;
  logic         flip_any;

  always #5 clk = ~clk;

  fault_injector dut_i (
    .clk(clk), .rst_n(rst_n), .inj_en(inj_en), .inj_mode(inj_mode),
    .seed_load(seed_load), .data_seed(data_seed), .sel_seed(sel_seed),
    .stuck_mask(stuck_mask), .stuck_val(stuck_val), .bus_in(bus_in),
    .bus_out(bus_out), .flip_any(flip_any), .flip_mask(flip_mask)
  );

  typedef struct {
    logic [W-1:0] dout;
    logic         any;
    logic [W-1:0] mask;
    int           req;
  } exp_t;

  exp_t q[$];
  int   errors = 0, checks = 0, fires_seen = 0;

  logic [15:0] m_sel;
  logic [7:0]  m_dat [16];

  // Reference registers, built from R2, R3 and R11
  function automatic logic [7:0] nx8(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
  function automatic logic [15:0] nx16(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic model_seed(input logic [7:0] ds, input logic [15:0] ss);
    m_sel = (ss == 16'd0) ? 16'hACE1 : ss;
    for (int k = 0; k < 16; k++) begin
      logic [7:0] s;
      s = ds + 8'(k);
      m_dat[k] = (s == 8'd0) ? 8'hFF : s;
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic check(input bit ok, input string what, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  // Driver: drive one cycle, predict outputs, advance the reference at the coming edge
  task automatic drive(input logic en, input logic [1:0] md, input logic ld,
                       input logic [7:0] ds, input logic [15:0] ss,
                       input logic [W-1:0] din, input logic [W-1:0] sm,
                       input logic [W-1:0] sv, input int req);
    exp_t e;
    logic [W-1:0] r;
    logic f;
    logic [15:0] mu;
    @(posedge clk); #1;
    inj_en = en; inj_mode = md; seed_load = ld; data_seed = ds; sel_seed = ss;
    bus_in = din; stuck_mask = sm; stuck_val = sv;
    r = '0;
    f = (m_sel[15:13] == 3'b000);                      // R4
    mu = m_sel ^ {m_sel[7:0], m_sel[15:8]};
    for (int k = 0; k < 16; k++) begin
      if (md == 2'd0 && f && m_sel[3:0] == 4'(k)) r[k*8 + int'(m_sel[6:4])] = 1'b1; // R5
      if (md == 2'd1 && f && m_sel[3:0] == 4'(k)) r[k*8 +: 8] = 8'hFF;             // R6
      if (md == 2'd2 && f && mu[k]) r[k*8 +: 8] = 8'hFF;                          // R7
    end
    if (!en) e.dout = din;                                          // R1
    else if (md == 2'd3) e.dout = (din & ~sm) | (sv & sm);           // R8
    else begin
      e.dout = din;
      for (int k = 0; k < 16; k++)
        for (int b = 0; b < 8; b++)
          if (r[k*8+b]) e.dout[k*8+b] = m_dat[k][b];
    end
    e.mask = e.dout ^ din;                                          // R9
    e.any  = |e.mask;
    e.req  = req;
    q.push_back(e);
    if (ld) model_seed(ds, ss);                                     // R10
    else if (en) begin                                              // R11
      m_sel = nx16(m_sel);
      for (int k = 0; k < 16; k++) m_dat[k] = nx8(m_dat[k]);
    end
  endtask

  // Monitor: compare each predicted item at the falling edge
  initial forever begin
    @(negedge clk);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(bus_out === e.dout, $sformatf("R%0d bus_out", e.req), bus_out, e.dout);
      check(flip_mask === e.mask, $sformatf("R%0d flip_mask", e.req), flip_mask, e.mask);
      check(flip_any === e.any, $sformatf("R%0d flip_any", e.req), W'(flip_any), W'(e.any));
      if (flip_any === 1'b1 && inj_mode != 2'd3) fires_seen++;
    end
  end

  function automatic logic [W-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic run(input int n, input logic [1:0] md, input int req, input int pat);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] d;
      d = (pat == 0) ? rnd() : (pat == 1) ? '0 : '1;
      drive(1'b1, md, 1'b0, 8'd0, 16'd0, d, rnd(), rnd(), req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    model_seed(8'd0, 16'd0);                 // R11 reset state
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 pass-through with disabled injection, registers must hold
    for (int i = 0; i < 20; i++) drive(1'b0, 2'(i % 4), 1'b0, 8'd0, 16'd0, rnd(), rnd(), rnd(), 1);
    // R11 reset contents observed through byte mode
    run(200, 2'd1, 11, 0);
    // R10 load seeds while disabled, output uses old state
    drive(1'b0, 2'd0, 1'b1, 8'h3C, 16'h1234, rnd(), '0, '0, 10);
    run(400, 2'd0, 5, 0);
    run(200, 2'd0, 5, 1);
    run(200, 2'd0, 5, 2);
    check(fires_seen > 0, "R4 firing cycles seen", W'(fires_seen), W'(1));
    // R6 / R7 with a fresh seed loaded while enabled
    drive(1'b1, 2'd1, 1'b1, 8'hA7, 16'hBEEF, rnd(), '0, '0, 10);
    run(400, 2'd1, 6, 0);
    run(200, 2'd1, 6, 1);
    run(400, 2'd2, 7, 0);
    run(200, 2'd2, 7, 2);
    // R2 / R3 zero-seed substitution; seed F1 makes lane 15 start at 0
    drive(1'b1, 2'd2, 1'b1, 8'd0, 16'd0, rnd(), '0, '0, 3);
    run(300, 2'd2, 2, 1);
    drive(1'b1, 2'd1, 1'b1, 8'hF1, 16'h0001, rnd(), '0, '0, 2);
    run(300, 2'd1, 2, 0);
    // R11 interleaved pauses
    for (int i = 0; i < 200; i++)
      drive(1'(i % 3 != 0), 2'd1, 1'b0, 8'd0, 16'd0, rnd(), '0, '0, 11);
    // R8 stuck-at, including all-forced and none-forced
    run(200, 2'd3, 8, 0);
    drive(1'b1, 2'd3, 1'b0, 8'd0, 16'd0, rnd(), '1, '0, 8);
    drive(1'b1, 2'd3, 1'b0, 8'd0, 16'd0, '0, '1, '1, 8);
    drive(1'b1, 2'd3, 1'b0, 8'd0, 16'd0, rnd(), '0, '1, 8);
    // R9 mask tracking back in bit mode after stuck-at
    run(300, 2'd0, 9, 0);
    @(posedge clk); @(posedge clk);
    summary();
    $finish;
  end
endmodule